// File: doc/BRIEF.md
# Block-Erasable Memory Command Sequencer

This block sits between a host bus and a byte-wide, block-erasable memory array. The host issues single-cycle bus writes that carry command codes, addresses and data. The block decodes one-, two- and three-cycle command sequences and checks each request against per-block lock bits and a master write-protect gate. It then drives a synchronous array port to program bytes or to erase whole blocks by writing all-ones to every location. A status byte and a ready output report progress. A running block erase can be suspended so that other blocks can be read, and then resumed.

The array is split into 2^BLK_W equal blocks, and the block index is the top BLK_W address bits. The reset defaults are a 19-bit address and 32 blocks. After reset the gate is closed and every block counts as locked. A write-protect set/confirm pair opens the gate and applies the real lock inputs. A global erase of unlocked blocks is accepted while the gate is still closed. It skips blocks whose lock input is set, and when it finishes it opens the gate. Operation lengths come from the cycle-count parameters PROG_CYC and ERASE_CYC.

The sequencer has these states:
- S_IDLE decodes commands.
- S_BW_DATA waits for the byte-write data cycle.
- S_TB_D1 and S_TB_D2 collect the two data cycles of a two-byte write.
- S_ER_CONF, S_WP_CONF and S_EA_CONF wait for the confirm cycles of a block erase, a write-protect set and an erase of all unlocked blocks.
- S_PROG programs bytes.
- S_ER_SWEEP writes all-ones through a block.
- S_ER_WAIT holds for the erase duration.
- S_EA_SCAN picks the next unlocked block during a global erase.
- S_ER_SUSP holds a suspended erase.

The transitions are:
- Each setup command moves S_IDLE to its second-cycle state.
- A confirm or data cycle that passes the checks starts S_PROG or S_ER_SWEEP, or for a global erase starts S_EA_SCAN.
- A wrong confirm or a lock rejection returns the block to S_IDLE.
- S_PROG returns to S_IDLE when its timer expires, after its second byte if a two-byte write is pending.
- S_ER_SWEEP moves to S_ER_WAIT after the last offset of the block.
- S_ER_WAIT returns to S_IDLE, or during a global erase goes back to S_EA_SCAN.
- S_EA_SCAN goes to S_ER_SWEEP, or to S_IDLE after the last block.
- A suspend moves S_ER_SWEEP or S_ER_WAIT to S_ER_SUSP, and a confirm resumes the phase that was suspended.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, rdy is 1, and a read-status command (0x70) followed by a read returns 0x80. The status byte holds, from bit 7 down: ready, erase suspended, erase error, write error, lock violation and sequence error. Bits 1:0 are zero.
- R2: A byte write is command 0x40 followed by a data cycle that carries the address and data. It stores the data at that address, and rdy is low for exactly PROG_CYC+1 cycles after the data cycle.
- R3: A two-byte write is 0xFB, then a cycle carrying (A, d0), then a cycle carrying d1. It stores d0 at A and d1 at A+1, with rdy low for 2*(PROG_CYC+1) cycles. If either byte falls in a locked block, neither byte is written and status bits 4 and 3 are set.
- R4: After reset, until a write-protect confirm or a completed global erase, byte writes and block erases leave the array unchanged and keep rdy high. A rejected write sets status bits 4 and 3, and a rejected erase sets bits 5 and 3.
- R5: The write-protect pair 0x57 then 0xD0 opens the gate. After that, operations on blocks whose lock input is set are still rejected, and operations on other blocks are carried out.
- R6: A block erase is 0x20 followed by 0xD0 at an address in the block. It sets every byte of that block to 0xFF and leaves the neighbouring blocks unchanged. rdy is low for exactly 2^(ADDR_W-BLK_W)+ERASE_CYC+1 cycles.
- R7: A suspend (0xB0) during a block erase raises rdy after that cycle and sets status bit 6. While suspended, no array write occurs and other blocks can be read. A confirm (0xD0) resumes the erase, which then completes the whole block and clears bit 6.
- R8: An erase of all unlocked blocks (0xA7 then 0xD0) is accepted even while the gate is closed. It sets to 0xFF only the blocks whose lock input is clear, and afterwards byte writes to unlocked blocks are carried out.
- R9: A second cycle other than 0xD0 after 0x20, 0x57 or 0xA7 sets status bit 2, returns to idle and modifies nothing.
- R10: The error bits (5 down to 2) stay set through other commands until the clear-status command 0x50 clears them.
- R11: While an operation runs, every command other than read-status and suspend is ignored. After completion, a following 0x70 is decoded as a command and does not start an operation.
- R12: After a read-array command (0xFF), a read returns the array byte at the address presented one cycle earlier. After 0x70, reads return the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Host write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Host address |
| bus_wdata | input | 8 | Host command or data byte |
| bus_rdata | output | 8 | Array byte or status byte |
| rdy | output | 1 | 1 when no operation is running |
| blk_lock_nv | input | 2^BLK_W | Stored per-block lock bits |
| arr_addr | output | ADDR_W | Array port address |
| arr_wdata | output | 8 | Array port write data |
| arr_we | output | 1 | Array port write enable |
| arr_rdata | input | 8 | Array port read data, one cycle latency |

## Verification
The program path is driven with three stimulus sets. Single byte writes at block starts, at the top address and in the middle of a block test address decoding and busy length. Two-byte writes inside a block and across a block boundary test the increment and the check of both lock bits, including a pair whose second byte lands in a locked block. Erases are driven three ways: a plain block erase, an erase that is suspended and resumed with a read of another block in between, and a global erase with two locked blocks. Comparing whole blocks against a bench copy of the array separates correct sweep bounds, skipped blocks and suspension that leaves data untouched. The same commands are sent before and after the gate opens, which tells apart rejection caused by the closed gate and rejection caused by a real lock bit.

// File: rtl/fcc_pkg.sv
`timescale 1ns/1ps
package fcc_pkg;
    localparam logic [7:0] OP_RD_ARR = 8'hFF;
    localparam logic [7:0] OP_RD_STS = 8'h70;
    localparam logic [7:0] OP_CLR    = 8'h50;
    localparam logic [7:0] OP_BW     = 8'h40;
    localparam logic [7:0] OP_TB     = 8'hFB;
    localparam logic [7:0] OP_ERS    = 8'h20;
    localparam logic [7:0] OP_CONF   = 8'hD0;
    localparam logic [7:0] OP_SUSP   = 8'hB0;
    localparam logic [7:0] OP_WP     = 8'h57;
    localparam logic [7:0] OP_EALL   = 8'hA7;

    localparam int ERR_SEQ  = 0;
    localparam int ERR_LOCK = 1;
    localparam int ERR_WR   = 2;
    localparam int ERR_ER   = 3;

    typedef enum logic [3:0] {
        S_IDLE,
        S_BW_DATA,
        S_TB_D1,
        S_TB_D2,
        S_PROG,
        S_ER_CONF,
        S_WP_CONF,
        S_EA_CONF,
        S_EA_SCAN,
        S_ER_SWEEP,
        S_ER_WAIT,
        S_ER_SUSP
    } fcc_state_e;
endpackage

// File: rtl/fcc_timer.sv
`timescale 1ns/1ps
module fcc_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             en,
    output logic             done
);
    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (en && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && cnt_q == '0) |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/fcc_lockbank.sv
`timescale 1ns/1ps
module fcc_lockbank #(
    parameter int BLK_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(1<<BLK_W)-1:0] nv_lock,
    input  logic                  open_req,
    input  logic [BLK_W-1:0]      blk_a,
    input  logic [BLK_W-1:0]      blk_b,
    output logic                  locked_a,
    output logic                  locked_b,
    output logic                  gate_open
);
    localparam int NUM_BLK = 1 << BLK_W;

    logic               gate_q;
    logic [NUM_BLK-1:0] eff_lock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if (open_req) begin
            gate_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_BLK; i++) begin : g_eff
        assign eff_lock[i] = !gate_q || nv_lock[i];
    end

    assign locked_a  = eff_lock[blk_a];
    assign locked_b  = eff_lock[blk_b];
    assign gate_open = gate_q;

    AST_GATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gate_q) |-> gate_q); // R5
endmodule

// File: rtl/fcc_errstat.sv
`timescale 1ns/1ps
module fcc_errstat #(
    parameter int N_ERR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ERR-1:0] set,
    input  logic             clr,
    output logic [N_ERR-1:0] err
);
    logic [N_ERR-1:0] err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= '0;
        end else if (clr) begin
            err_q <= '0;
        end else begin
            err_q <= err_q | set;
        end
    end

    assign err = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((err_q & $past(err_q)) == $past(err_q))); // R10
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl #(
    parameter int ADDR_W    = 19,
    parameter int BLK_W     = 5,
    parameter int TMR_W     = 16,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [7:0]            bus_wdata,
    output logic [7:0]            bus_rdata,
    output logic                  rdy,
    input  logic [(1<<BLK_W)-1:0] blk_lock_nv,
    output logic [ADDR_W-1:0]     arr_addr,
    output logic [7:0]            arr_wdata,
    output logic                  arr_we,
    input  logic [7:0]            arr_rdata
);
    import fcc_pkg::*;

    localparam int OFS_W = ADDR_W - BLK_W;
    localparam logic [TMR_W-1:0] PROG_LD = TMR_W'(PROG_CYC);
    localparam logic [TMR_W-1:0] ERS_LD  = TMR_W'(ERASE_CYC);

    fcc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d, addr_inc;
    logic [7:0]        dat0_q, dat0_d, dat1_q, dat1_d;
    logic              two_q, two_d;
    logic [BLK_W-1:0]  blk_q, blk_d;
    logic              eall_q, eall_d;
    logic              resw_q, resw_d;
    logic              rdarr_q, rdarr_d;

    logic [3:0]        set_err, err;
    logic              clr_err, open_gate, gate_open;
    logic              tmr_load, tmr_en, tmr_done;
    logic [TMR_W-1:0]  tmr_val;
    logic [BLK_W-1:0]  qa_blk, qb_blk;
    logic              locked_a, locked_b;
    logic              busy_st, susp_req, sweep_last;
    logic [7:0]        status;

    assign addr_inc   = addr_q + {{(ADDR_W-1){1'b0}}, 1'b1};
    assign qa_blk     = (state_q == S_TB_D2) ? addr_q[ADDR_W-1 -: BLK_W] : bus_addr[ADDR_W-1 -: BLK_W];
    assign qb_blk     = addr_inc[ADDR_W-1 -: BLK_W];
    assign busy_st    = (state_q == S_PROG) || (state_q == S_ER_SWEEP) ||
                        (state_q == S_ER_WAIT) || (state_q == S_EA_SCAN);
    assign susp_req   = bus_we && (bus_wdata == OP_SUSP) && !eall_q;
    assign sweep_last = &addr_q[OFS_W-1:0];
    assign tmr_en     = (state_q == S_PROG) || (state_q == S_ER_WAIT);

    fcc_lockbank #(.BLK_W(BLK_W)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .nv_lock  (blk_lock_nv),
        .open_req (open_gate),
        .blk_a    (qa_blk),
        .blk_b    (qb_blk),
        .locked_a (locked_a),
        .locked_b (locked_b),
        .gate_open(gate_open)
    );

    fcc_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .en      (tmr_en),
        .done    (tmr_done)
    );

    fcc_errstat #(.N_ERR(4)) u_err (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (set_err),
        .clr  (clr_err),
        .err  (err)
    );

    // State register and sequencing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            dat0_q  <= '0;
            dat1_q  <= '0;
            two_q   <= 1'b0;
            blk_q   <= '0;
            eall_q  <= 1'b0;
            resw_q  <= 1'b0;
            rdarr_q <= 1'b1;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            dat0_q  <= dat0_d;
            dat1_q  <= dat1_d;
            two_q   <= two_d;
            blk_q   <= blk_d;
            eall_q  <= eall_d;
            resw_q  <= resw_d;
            rdarr_q <= rdarr_d;
        end
    end

    // Next state and command decode
    always_comb begin
        state_d   = state_q;
        addr_d    = addr_q;
        dat0_d    = dat0_q;
        dat1_d    = dat1_q;
        two_d     = two_q;
        blk_d     = blk_q;
        eall_d    = eall_q;
        resw_d    = resw_q;
        rdarr_d   = rdarr_q;
        set_err   = '0;
        clr_err   = 1'b0;
        open_gate = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = PROG_LD;

        if (busy_st && bus_we && bus_wdata == OP_RD_STS) begin
            rdarr_d = 1'b0;
        end

        unique case (state_q)
            S_IDLE: begin
                if (bus_we) begin
                    case (bus_wdata)
                        OP_RD_ARR: rdarr_d = 1'b1;
                        OP_RD_STS: rdarr_d = 1'b0;
                        OP_CLR:    clr_err = 1'b1;
                        OP_BW:   begin state_d = S_BW_DATA; rdarr_d = 1'b0; end
                        OP_TB:   begin state_d = S_TB_D1;   rdarr_d = 1'b0; end
                        OP_ERS:  begin state_d = S_ER_CONF; rdarr_d = 1'b0; end
                        OP_WP:   begin state_d = S_WP_CONF; rdarr_d = 1'b0; end
                        OP_EALL: begin state_d = S_EA_CONF; rdarr_d = 1'b0; end
                        default: ;
                    endcase
                end
            end
            S_BW_DATA: begin
                if (bus_we) begin
                    if (locked_a) begin
                        set_err[ERR_WR]   = 1'b1;
                        set_err[ERR_LOCK] = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        addr_d   = bus_addr;
                        dat0_d   = bus_wdata;
                        two_d    = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = PROG_LD;
                        state_d  = S_PROG;
                    end
                end
            end
            S_TB_D1: begin
                if (bus_we) begin
                    addr_d  = bus_addr;
                    dat0_d  = bus_wdata;
                    state_d = S_TB_D2;
                end
            end
            S_TB_D2: begin
                if (bus_we) begin
                    if (locked_a || locked_b) begin
                        set_err[ERR_WR]   = 1'b1;
                        set_err[ERR_LOCK] = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        dat1_d   = bus_wdata;
                        two_d    = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = PROG_LD;
                        state_d  = S_PROG;
                    end
                end
            end
            S_PROG: begin
                if (tmr_done) begin
                    if (two_q) begin
                        addr_d   = addr_inc;
                        dat0_d   = dat1_q;
                        two_d    = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = PROG_LD;
                    end else begin
                        state_d = S_IDLE;
                    end
                end
            end
            S_ER_CONF: begin
                if (bus_we) begin
                    state_d = S_IDLE;
                    if (bus_wdata != OP_CONF) begin
                        set_err[ERR_SEQ] = 1'b1;
                    end else if (locked_a) begin
                        set_err[ERR_ER]   = 1'b1;
                        set_err[ERR_LOCK] = 1'b1;
                    end else begin
                        addr_d  = {bus_addr[ADDR_W-1 -: BLK_W], {OFS_W{1'b0}}};
                        eall_d  = 1'b0;
                        state_d = S_ER_SWEEP;
                    end
                end
            end
            S_WP_CONF: begin
                if (bus_we) begin
                    state_d = S_IDLE;
                    if (bus_wdata == OP_CONF) begin
                        open_gate = 1'b1;
                    end else begin
                        set_err[ERR_SEQ] = 1'b1;
                    end
                end
            end
            S_EA_CONF: begin
                if (bus_we) begin
                    if (bus_wdata == OP_CONF) begin
                        eall_d  = 1'b1;
                        blk_d   = '0;
                        state_d = S_EA_SCAN;
                    end else begin
                        set_err[ERR_SEQ] = 1'b1;
                        state_d = S_IDLE;
                    end
                end
            end
            S_EA_SCAN: begin
                if (!blk_lock_nv[blk_q]) begin
                    addr_d  = {blk_q, {OFS_W{1'b0}}};
                    state_d = S_ER_SWEEP;
                end else if (&blk_q) begin
                    open_gate = 1'b1;
                    eall_d    = 1'b0;
                    state_d   = S_IDLE;
                end else begin
                    blk_d = blk_q + 1'b1;
                end
            end
            S_ER_SWEEP: begin
                if (susp_req) begin
                    resw_d  = 1'b0;
                    state_d = S_ER_SUSP;
                end else begin
                    addr_d = addr_inc;
                    if (sweep_last) begin
                        tmr_load = 1'b1;
                        tmr_val  = ERS_LD;
                        state_d  = S_ER_WAIT;
                    end
                end
            end
            S_ER_WAIT: begin
                if (susp_req) begin
                    resw_d  = 1'b1;
                    state_d = S_ER_SUSP;
                end else if (tmr_done) begin
                    if (!eall_q) begin
                        state_d = S_IDLE;
                    end else if (&blk_q) begin
                        open_gate = 1'b1;
                        eall_d    = 1'b0;
                        state_d   = S_IDLE;
                    end else begin
                        blk_d   = blk_q + 1'b1;
                        state_d = S_EA_SCAN;
                    end
                end
            end
            S_ER_SUSP: begin
                if (bus_we) begin
                    case (bus_wdata)
                        OP_RD_ARR: rdarr_d = 1'b1;
                        OP_RD_STS: rdarr_d = 1'b0;
                        OP_CLR:    clr_err = 1'b1;
                        OP_CONF: begin
                            rdarr_d = 1'b0;
                            state_d = resw_q ? S_ER_WAIT : S_ER_SWEEP;
                        end
                        default: ;
                    endcase
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        arr_we    = ((state_q == S_PROG) && tmr_done) ||
                    ((state_q == S_ER_SWEEP) && !susp_req);
        arr_addr  = ((state_q == S_PROG) || (state_q == S_ER_SWEEP)) ? addr_q : bus_addr;
        arr_wdata = (state_q == S_ER_SWEEP) ? 8'hFF : dat0_q;
        rdy       = !busy_st;
        status    = {rdy, (state_q == S_ER_SUSP), err[ERR_ER], err[ERR_WR],
                     err[ERR_LOCK], err[ERR_SEQ], 2'b00};
        bus_rdata = (rdarr_q && rdy) ? arr_rdata : status;
    end

    AST_NO_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !blk_lock_nv[arr_addr[ADDR_W-1 -: BLK_W]]); // R5
    AST_GATE_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && !eall_q) |-> gate_open); // R4
    AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !rdy); // R11
    AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q == S_ER_SUSP) && state_q == S_ER_SUSP) |-> $stable(addr_q)); // R7
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
    localparam int AW    = 10;
    localparam int BW    = 5;
    localparam int BSZ   = 1 << (AW - BW);
    localparam int NB    = 1 << BW;
    localparam int PCYC  = 4;
    localparam int ECYC  = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          rdy;
    logic [NB-1:0] lock_nv = 32'h0000_0005;
    logic [AW-1:0] arr_addr;
    logic [7:0]    arr_wdata;
    logic          arr_we;
    logic [7:0]    arr_rdata = '0;

    logic [7:0] mem [0:DEPTH-1];
    logic [7:0] ref_mem [0:DEPTH-1];
    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .BLK_W(BW), .TMR_W(8), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rdy(rdy),
        .blk_lock_nv(lock_nv), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_we(arr_we), .arr_rdata(arr_rdata)
    );

    always @(posedge clk) begin
        if (arr_we) mem[arr_addr] <= arr_wdata;
        arr_rdata <= mem[arr_addr];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = AW'(a);
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic rd_status(output logic [7:0] v);
        bus_wr(0, 8'h70);
        rd(0, v);
    endtask

    task automatic wait_rdy(output int cnt);
        cnt = 0;
        while (!rdy && cnt < 100000) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic cmp_blk(input int b, input string tag);
        int bad = 0;
        for (int i = 0; i < BSZ; i++)
            if (mem[b*BSZ+i] !== ref_mem[b*BSZ+i]) bad++;
        chk(bad == 0, tag, bad, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [7:0] s;
        chk(rdy == 1'b1, "R1 rdy after reset", int'(rdy), 1);
        rd_status(s);
        chk(s == 8'h80, "R1 status after reset", s, 8'h80);
    endtask

    task automatic t_gate_reject();
        logic [7:0] s;
        bus_wr(0, 8'h40); bus_wr(97, 8'h11);
        chk(rdy == 1'b1, "R4 write rejected rdy", int'(rdy), 1);
        rd_status(s);
        chk(s == 8'h98, "R4 write reject status", s, 8'h98);
        bus_wr(0, 8'h20); bus_wr(4*BSZ, 8'hD0);
        chk(rdy == 1'b1, "R4 erase rejected rdy", int'(rdy), 1);
        rd_status(s);
        chk(s == 8'hB8, "R4 erase reject status", s, 8'hB8);
        repeat (3) @(negedge clk);
        chk(mem[97] == ref_mem[97], "R4 byte unchanged", mem[97], ref_mem[97]);
        cmp_blk(4, "R4 block 4 unchanged");
    endtask

    task automatic t_err_clear();
        logic [7:0] s;
        bus_wr(0, 8'hFF);
        rd_status(s);
        chk(s == 8'hB8, "R10 errors persist", s, 8'hB8);
        bus_wr(0, 8'h50);
        rd_status(s);
        chk(s == 8'h80, "R10 errors cleared", s, 8'h80);
    endtask

    task automatic t_seq_err();
        logic [7:0] s;
        bus_wr(0, 8'h20); bus_wr(5*BSZ, 8'hFF);
        chk(rdy == 1'b1, "R9 no erase started", int'(rdy), 1);
        rd_status(s);
        chk(s == 8'h84, "R9 sequence error bit", s, 8'h84);
        bus_wr(0, 8'hA7); bus_wr(0, 8'h33);
        rd_status(s);
        chk(s == 8'h84, "R9 erase-all mismatch", s, 8'h84);
        cmp_blk(5, "R9 block 5 unchanged");
        bus_wr(0, 8'h50);
    endtask

    task automatic t_erase_all();
        int c;
        logic [7:0] s;
        bus_wr(0, 8'hA7); bus_wr(0, 8'hD0);
        chk(rdy == 1'b0, "R8 global erase started", int'(rdy), 0);
        wait_rdy(c);
        for (int b = 0; b < NB; b++)
            if (!lock_nv[b])
                for (int i = 0; i < BSZ; i++) ref_mem[b*BSZ+i] = 8'hFF;
        cmp_blk(0, "R8 locked block 0 kept");
        cmp_blk(2, "R8 locked block 2 kept");
        cmp_blk(1, "R8 block 1 erased");
        cmp_blk(31, "R8 block 31 erased");
        bus_wr(0, 8'h40); bus_wr(97, 8'h11);
        wait_rdy(c);
        ref_mem[97] = 8'h11;
        chk(mem[97] == 8'h11, "R8 write after global erase", mem[97], 8'h11);
        rd_status(s);
        chk(s == 8'h80, "R8 clean status", s, 8'h80);
    endtask

    task automatic t_wp();
        logic [7:0] s;
        int c;
        bus_wr(0, 8'h40); bus_wr(100, 8'h22);
        rd_status(s);
        chk(s == 8'h98, "R4 gate closed again after reset", s, 8'h98);
        bus_wr(0, 8'h50);
        bus_wr(0, 8'h57); bus_wr(0, 8'h12);
        rd_status(s);
        chk(s == 8'h84, "R9 wp mismatch", s, 8'h84);
        bus_wr(0, 8'h50);
        bus_wr(0, 8'h57); bus_wr(0, 8'hD0);
        bus_wr(0, 8'h40); bus_wr(5, 8'h33);
        rd_status(s);
        chk(s == 8'h98, "R5 locked block refused", s, 8'h98);
        chk(mem[5] == ref_mem[5], "R5 locked byte kept", mem[5], ref_mem[5]);
        bus_wr(0, 8'h50);
        bus_wr(0, 8'h40); bus_wr(100, 8'h5C);
        wait_rdy(c);
        ref_mem[100] = 8'h5C;
        chk(mem[100] == 8'h5C, "R5 unlocked block written", mem[100], 8'h5C);
    endtask

    task automatic t_byte(input int a, input logic [7:0] d);
        int c;
        bus_wr(0, 8'h40); bus_wr(a, d);
        wait_rdy(c);
        ref_mem[a] = d;
        chk(c == PCYC + 1, "R2 busy length", c, PCYC + 1);
        chk(mem[a] == d, "R2 byte stored", mem[a], d);
    endtask

    task automatic t_two(input int a, input logic [7:0] d0, input logic [7:0] d1);
        int c;
        bus_wr(0, 8'hFB); bus_wr(a, d0); bus_wr(0, d1);
        wait_rdy(c);
        ref_mem[a] = d0; ref_mem[a+1] = d1;
        chk(c == 2 * (PCYC + 1), "R3 busy length", c, 2 * (PCYC + 1));
        chk(mem[a] == d0, "R3 first byte", mem[a], d0);
        chk(mem[a+1] == d1, "R3 second byte", mem[a+1], d1);
    endtask

    task automatic t_two_locked();
        logic [7:0] s;
        bus_wr(0, 8'hFB); bus_wr(63, 8'h01); bus_wr(0, 8'h02);
        chk(rdy == 1'b1, "R3 cross into locked rejected", int'(rdy), 1);
        rd_status(s);
        chk(s == 8'h98, "R3 cross lock status", s, 8'h98);
        chk(mem[63] == ref_mem[63] && mem[64] == ref_mem[64], "R3 neither byte written", mem[63], ref_mem[63]);
        bus_wr(0, 8'h50);
    endtask

    task automatic t_erase();
        int c;
        bus_wr(0, 8'h20); bus_wr(7*BSZ + 3, 8'hD0);
        wait_rdy(c);
        for (int i = 0; i < BSZ; i++) ref_mem[7*BSZ+i] = 8'hFF;
        chk(c == BSZ + ECYC + 1, "R6 busy length", c, BSZ + ECYC + 1);
        cmp_blk(7, "R6 block erased");
        cmp_blk(6, "R6 lower neighbour kept");
        cmp_blk(8, "R6 upper neighbour kept");
    endtask

    task automatic t_suspend();
        int c;
        logic [7:0] s, v;
        bus_wr(0, 8'h20); bus_wr(9*BSZ, 8'hD0);
        repeat (4) @(negedge clk);
        bus_wr(0, 8'hB0);
        chk(rdy == 1'b1, "R7 ready when suspended", int'(rdy), 1);
        rd_status(s);
        chk(s == 8'hC0, "R7 suspended status", s, 8'hC0);
        repeat (5) @(negedge clk);
        chk(mem[9*BSZ+BSZ-1] == ref_mem[9*BSZ+BSZ-1], "R7 no write while suspended",
            mem[9*BSZ+BSZ-1], ref_mem[9*BSZ+BSZ-1]);
        bus_wr(0, 8'hFF);
        rd(10*BSZ + 3, v);
        chk(v == ref_mem[10*BSZ+3], "R7 read other block", v, ref_mem[10*BSZ+3]);
        bus_wr(0, 8'hD0);
        wait_rdy(c);
        for (int i = 0; i < BSZ; i++) ref_mem[9*BSZ+i] = 8'hFF;
        cmp_blk(9, "R7 resumed erase complete");
        cmp_blk(10, "R7 other block kept");
        rd_status(s);
        chk(s == 8'h80, "R7 suspend bit cleared", s, 8'h80);
    endtask

    task automatic t_busy_ignore();
        int c;
        logic [7:0] s;
        bus_wr(0, 8'h40); bus_wr(330, 8'h77);
        bus_wr(0, 8'h40);
        wait_rdy(c);
        ref_mem[330] = 8'h77;
        bus_wr(0, 8'h70);
        chk(rdy == 1'b1, "R11 no op after ignored setup", int'(rdy), 1);
        repeat (3) @(negedge clk);
        chk(rdy == 1'b1, "R11 stays ready", int'(rdy), 1);
        rd(0, s);
        chk(s == 8'h80, "R11 status clean", s, 8'h80);
        chk(mem[330] == 8'h77, "R11 original write done", mem[330], 8'h77);
        cmp_blk(0, "R11 block 0 untouched");
    endtask

    task automatic t_read_modes();
        logic [7:0] v;
        bus_wr(0, 8'hFF);
        rd(100, v);
        chk(v == 8'h5C, "R12 read array", v, 8'h5C);
        rd(330, v);
        chk(v == 8'h77, "R12 read array second address", v, 8'h77);
        bus_wr(0, 8'h70);
        rd(100, v);
        chk(v == 8'h80, "R12 status mode read", v, 8'h80);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = 8'(i) ^ 8'h5A;
            ref_mem[i] = 8'(i) ^ 8'h5A;
        end
        do_reset();
        t_reset_state();
        t_gate_reject();
        t_err_clear();
        t_seq_err();
        t_erase_all();
        do_reset();
        t_wp();
        t_byte(96, 8'h00);
        t_byte(DEPTH - 1, 8'hA5);
        t_byte(500, 8'h3C);
        t_two(200, 8'h3C, 8'hC3);
        t_two(5*BSZ + BSZ - 1, 8'h81, 8'h18);
        t_two_locked();
        t_erase();
        t_suspend();
        t_busy_ignore();
        t_read_modes();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #750000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule